// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block collects up to 32 interrupt request lines, latches each into a per-source pending bit and presents the result to a processor. Each source can be sensed on its level or on an edge, and it can be active-high or active-low. A pending bit only reaches the outputs when its enable bit is set. Enabled, pending sources are split into two outputs, critical and non-critical, by a per-source routing register. A priority encoder reports the lowest-numbered enabled pending source, and a separate flag says when nothing is pending.

Software reaches the block through a plain single-cycle register port with an address, write data, a write strobe and combinational read data. There is no stream data path, so the port has no valid/ready handshake and never applies back-pressure: a write takes effect on the clock edge where the strobe is high, and a read returns the addressed register in the same cycle. Register bit (31 − n) belongs to source n, so source 0 is the most significant bit and has the highest priority. Addresses are 0 pending (write one to clear), 1 enable, 2 enabled-pending (read only), 3 sense mode, 4 polarity and 5 critical routing; addresses 6 and 7 read as zero.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, enable and enabled-pending registers read zero, both interrupt outputs are low and the none-pending flag is high.
- R2: Source n (input src_i[n]) sets register bit (31 − n) of the pending register.
- R3: A level-sensed source (sense bit 0) keeps setting its pending bit while active, so a clear written while it is still active leaves the bit set.
- R4: An edge-sensed source (sense bit 1) sets its pending bit only on an inactive-to-active transition; after a clear the bit stays zero while the input holds its active level.
- R5: Polarity bit 1 makes high (or a rising edge) active; polarity bit 0 makes low (or a falling edge) active.
- R6: Writing address 0 clears every pending bit written as 1 and leaves bits written as 0 unchanged; writing all ones clears every pending bit that has no new event.
- R7: When a clear and a new event hit the same pending bit on the same edge, the bit is set afterwards.
- R8: Address 2 reads the bitwise AND of the pending and enable registers.
- R9: pend_id_o gives the number of the lowest-numbered enabled pending source and pend_none_o is 1 exactly when no enabled pending source exists (pend_id_o is then 0).
- R10: irq_crit_o is high when an enabled pending source has its routing bit at 1; irq_ncrit_o is high when an enabled pending source has its routing bit at 0.
- R11: An input change reaches the pending register on the third rising clock edge after it, and the outputs follow the enabled-pending value one edge later.
- R12: Enable, sense, polarity and routing registers read back the last value written to them, and writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt request lines, bit n is source n |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_wr_i | input | 1 | Write strobe, one write per cycle |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_crit_o | output | 1 | Critical interrupt request |
| irq_ncrit_o | output | 1 | Non-critical interrupt request |
| pend_id_o | output | 5 | Lowest-numbered enabled pending source |
| pend_none_o | output | 1 | No enabled source pending |

## Verification
The assertions assume the register port is driven with known values whenever reset is released and that the request lines may change at any time, since they pass through the synchronizer before any property samples them. The event-wins and clear-all properties rely on the internal event vector being the only way a pending bit is set, which holds for any input pattern. The stimulus changes the request lines and the port only on the falling clock edge, keeps every address within the three-bit range, and mixes directed sequences for each sense and polarity mode with a long pseudo-random run of input flips and register writes, so no input ever violates these assumptions.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Width of the register address.
  localparam int ADDR_W = 3;

  // Register addresses of the controller.
  typedef enum logic [ADDR_W-1:0] {
    RA_STAT  = 3'd0,  // pending events, write one to clear
    RA_ENAB  = 3'd1,  // per-source enable
    RA_MSTAT = 3'd2,  // pending AND enable, read only
    RA_TRIG  = 3'd3,  // 0 level, 1 edge
    RA_POL   = 3'd4,  // 1 active-high or rising, 0 active-low or falling
    RA_CRIT  = 3'd5   // 1 routes to the critical output
  } reg_addr_e;

endpackage

// File: rtl/irq_sync2.sv
// Two-stage synchronizer for asynchronous request lines.
module irq_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/irq_event.sv
// Per-source polarity adjustment and level / edge event detection.
// Inputs are indexed by source number, outputs by register bit.
module irq_event #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl_i,   // synchronized, bit n = source n
  input  logic [NSRC-1:0] pol_i,   // register bit order
  input  logic [NSRC-1:0] trig_i,  // register bit order
  output logic [NSRC-1:0] ev_o     // register bit order
);

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam int RB = NSRC - 1 - g;

      logic act;
      logic act_q;

      // Active when the line matches the selected polarity.
      assign act = pol_i[RB] ? lvl_i[g] : ~lvl_i[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
      end

      assign ev_o[RB] = trig_i[RB] ? (act & ~act_q) : act;
    end
  endgenerate

endmodule

// File: rtl/irq_regfile.sv
// Register bank: pending status, enable, sense, polarity, routing.
module irq_regfile
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   ev_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic [NSRC-1:0]   stat_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   trig_o,
  output logic [NSRC-1:0]   pol_o,
  output logic [NSRC-1:0]   csel_o,
  output logic [NSRC-1:0]   mstat_o
);

  logic [NSRC-1:0] stat_q, en_q, trig_q, pol_q, csel_q;
  logic [NSRC-1:0] clr_mask;
  logic            wr_stat, wr_en, wr_trig, wr_pol, wr_csel;

  assign wr_stat = wr_i && (addr_i == RA_STAT);
  assign wr_en   = wr_i && (addr_i == RA_ENAB);
  assign wr_trig = wr_i && (addr_i == RA_TRIG);
  assign wr_pol  = wr_i && (addr_i == RA_POL);
  assign wr_csel = wr_i && (addr_i == RA_CRIT);

  assign clr_mask = wr_stat ? wdata_i : '0;

  // Pending bits: new events take precedence over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      trig_q <= '0;
      pol_q  <= '1;
      csel_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata_i;
      if (wr_trig) trig_q <= wdata_i;
      if (wr_pol)  pol_q  <= wdata_i;
      if (wr_csel) csel_q <= wdata_i;
    end
  end

  assign mstat_o = stat_q & en_q;

  always_comb begin
    unique case (addr_i)
      RA_STAT:  rdata_o = stat_q;
      RA_ENAB:  rdata_o = en_q;
      RA_MSTAT: rdata_o = mstat_o;
      RA_TRIG:  rdata_o = trig_q;
      RA_POL:   rdata_o = pol_q;
      RA_CRIT:  rdata_o = csel_q;
      default:  rdata_o = '0;
    endcase
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign trig_o = trig_q;
  assign pol_o  = pol_q;
  assign csel_o = csel_q;

endmodule

// File: rtl/irq_prio_enc.sv
// Routing to critical / non-critical requests and priority encoding,
// all registered.
module irq_prio_enc #(
  parameter int NSRC = 32,
  parameter int IDW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] mstat_i,
  input  logic [NSRC-1:0] csel_i,
  output logic            crit_o,
  output logic            ncrit_o,
  output logic [IDW-1:0]  id_o,
  output logic            none_o
);

  logic [IDW-1:0] id_d;
  logic           any_d;

  // Scan from the least significant bit upward so the most significant
  // set bit (lowest source number) is assigned last and wins.
  always_comb begin
    id_d  = '0;
    any_d = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (mstat_i[i]) begin
        id_d  = IDW'(NSRC - 1 - i);
        any_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_o  <= 1'b0;
      ncrit_o <= 1'b0;
      id_o    <= '0;
      none_o  <= 1'b1;
    end else begin
      crit_o  <= |(mstat_i & csel_i);
      ncrit_o <= |(mstat_i & ~csel_i);
      id_o    <= id_d;
      none_o  <= ~any_d;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top level of the programmable interrupt controller.
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  input  logic              reg_wr_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_crit_o,
  output logic              irq_ncrit_o,
  output logic [IDW-1:0]    pend_id_o,
  output logic              pend_none_o
);

  logic [NSRC-1:0] src_sync;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] stat_q, en_q, trig_q, pol_q, csel_q, mstat;

  irq_sync2 #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irq_event #(.NSRC(NSRC)) u_event (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (src_sync),
    .pol_i  (pol_q),
    .trig_i (trig_q),
    .ev_o   (evt)
  );

  irq_regfile #(.NSRC(NSRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ev_i    (evt),
    .rdata_o (reg_rdata_o),
    .stat_o  (stat_q),
    .en_o    (en_q),
    .trig_o  (trig_q),
    .pol_o   (pol_q),
    .csel_o  (csel_q),
    .mstat_o (mstat)
  );

  irq_prio_enc #(.NSRC(NSRC), .IDW(IDW)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .mstat_i (mstat),
    .csel_i  (csel_q),
    .crit_o  (irq_crit_o),
    .ncrit_o (irq_ncrit_o),
    .id_o    (pend_id_o),
    .none_o  (pend_none_o)
  );

endmodule

// File: rtl/irq_prio_chk.sv
// Assertion checker, bound to the controller top.
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NSRC-1:0]   wdata_i,
  input logic [NSRC-1:0]   status,
  input logic [NSRC-1:0]   enable,
  input logic [NSRC-1:0]   csel,
  input logic [NSRC-1:0]   ev,
  input logic              crit,
  input logic              ncrit,
  input logic              none
);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == RA_STAT && wdata_i == {NSRC{1'b1}} && ev == '0)
    |=> (status == '0));

  // R12
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == RA_ENAB) |=> $stable(enable));

  // R9
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none |-> (!crit && !ncrit));

  // R9
  some_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !none |-> $past((status & enable) != '0));

  // R10
  crit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit |-> $past((status & enable & csel) != '0));

endmodule

bind irq_prio_ctrl irq_prio_chk #(.NSRC(NSRC)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_i    (reg_wr_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .status  (stat_q),
  .enable  (en_q),
  .csel    (csel_q),
  .ev      (evt),
  .crit    (irq_crit_o),
  .ncrit   (irq_ncrit_o),
  .none    (pend_none_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_crit, irq_ncrit, pend_none;
  logic [4:0]  pend_id;

  int total = 0;
  int fails = 0;
  bit done = 0;
  bit live = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_wr_i    (reg_wr),
    .reg_rdata_o (reg_rdata),
    .irq_crit_o  (irq_crit),
    .irq_ncrit_o (irq_ncrit),
    .pend_id_o   (pend_id),
    .pend_none_o (pend_none)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_st, m_en, m_trig, m_pol, m_csel, prev_adj;
  logic [31:0] msk, raw, adj, ev, clr;
  logic [31:0] hist[$];
  logic e_crit, e_ncrit, e_none;
  int   e_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_trig = '0; m_pol = '1; m_csel = '0;
      prev_adj = '0;
      e_crit = 0; e_ncrit = 0; e_none = 1; e_id = 0;
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
    end else begin
      msk     = m_st & m_en;
      e_crit  = |(msk & m_csel);
      e_ncrit = |(msk & ~m_csel);
      e_none  = (msk == 0);
      e_id    = 0;
      for (int n = 31; n >= 0; n--) if (msk[31-n]) e_id = n;
      raw = hist[hist.size()-2];
      for (int b = 0; b < 32; b++) begin
        adj[b] = m_pol[b] ? raw[31-b] : !raw[31-b];
        ev[b]  = m_trig[b] ? (adj[b] && !prev_adj[b]) : adj[b];
      end
      clr  = (reg_wr && reg_addr == 3'd0) ? reg_wdata : '0;
      m_st = (m_st & ~clr) | ev;
      prev_adj = adj;
      if (reg_wr) begin
        case (reg_addr)
          3'd1: m_en   = reg_wdata;
          3'd3: m_trig = reg_wdata;
          3'd4: m_pol  = reg_wdata;
          3'd5: m_csel = reg_wdata;
          default: ;
        endcase
      end
      hist.push_back(src);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_st;
      3'd1: return m_en;
      3'd2: return m_st & m_en;
      3'd3: return m_trig;
      3'd4: return m_pol;
      3'd5: return m_csel;
      default: return '0;
    endcase
  endfunction

  // Compare on every clock, 3 ns after the rising edge.
  always @(posedge clk) begin
    #3;
    if (rst_n && live && !done) begin
      chk(irq_crit == e_crit, "R10 crit", 32'(irq_crit), 32'(e_crit));
      chk(irq_ncrit == e_ncrit, "R10 ncrit", 32'(irq_ncrit), 32'(e_ncrit));
      chk(pend_none == e_none, "R9 none", 32'(pend_none), 32'(e_none));
      chk(int'(pend_id) == e_id, "R9 id", 32'(pend_id), 32'(e_id));
      if (reg_addr == 3'd0)
        chk(reg_rdata == m_read(reg_addr), "R6 read", reg_rdata, m_read(reg_addr));
      else if (reg_addr == 3'd2)
        chk(reg_rdata == m_read(reg_addr), "R8 read", reg_rdata, m_read(reg_addr));
      else
        chk(reg_rdata == m_read(reg_addr), "R12 read", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] m,
                    input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk((reg_rdata & m) == exp, tag, reg_rdata & m, exp);
  endtask

  function automatic logic [31:0] bit_of(input int src_no);
    return 32'h1 << (31 - src_no);
  endfunction

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    ticks(3);
    rst_n = 1'b1;
    live = 1'b1;
    tick();

    // R1 reset state
    rd(3'd0, '1, '0, "R1 status");
    rd(3'd1, '1, '0, "R1 enable");
    rd(3'd2, '1, '0, "R1 masked");
    chk(!irq_crit && !irq_ncrit, "R1 outputs", {irq_crit, irq_ncrit}, 0);
    chk(pend_none == 1'b1, "R1 none", 32'(pend_none), 1);

    wr(3'd1, '1);
    wr(3'd0, '1);

    // R11 / R2: level source 5 -> bit 26
    src[5] = 1'b1;
    ticks(2);
    rd(3'd0, bit_of(5), 0, "R11 not yet latched");
    tick();
    rd(3'd0, '1, bit_of(5), "R2 bit position");
    chk(irq_ncrit == 1'b0, "R11 output lag", 32'(irq_ncrit), 0);
    tick();
    chk(irq_ncrit == 1'b1, "R11 output", 32'(irq_ncrit), 1);
    chk(pend_id == 5'd5, "R9 id single", 32'(pend_id), 5);

    // R3: clear while level still active
    wr(3'd0, bit_of(5));
    rd(3'd0, bit_of(5), bit_of(5), "R3 level re-set");
    src[5] = 1'b0;
    ticks(3);
    wr(3'd0, bit_of(5));
    rd(3'd0, bit_of(5), 0, "R6 clear");

    // R4: edge source 3
    wr(3'd3, bit_of(3));
    src[3] = 1'b1;
    ticks(3);
    rd(3'd0, bit_of(3), bit_of(3), "R4 rising edge");
    wr(3'd0, bit_of(3));
    rd(3'd0, bit_of(3), 0, "R4 cleared");
    ticks(3);
    rd(3'd0, bit_of(3), 0, "R4 held level ignored");
    src[3] = 1'b0;
    ticks(3);
    rd(3'd0, bit_of(3), 0, "R5 falling edge ignored");

    // R7: edge arrives on the clearing edge
    src[3] = 1'b1;
    ticks(2);
    wr(3'd0, bit_of(3));
    rd(3'd0, bit_of(3), bit_of(3), "R7 event wins");
    wr(3'd0, '1);
    rd(3'd0, '1, 0, "R6 clear all");

    // R5: active-low level on source 9
    wr(3'd4, ~bit_of(9));
    tick();
    rd(3'd0, bit_of(9), bit_of(9), "R5 active low");
    src[9] = 1'b1;
    ticks(3);
    wr(3'd0, bit_of(9));
    rd(3'd0, bit_of(9), 0, "R5 inactive high");

    // R9: priority between sources 6 and 20
    wr(3'd0, '1);
    src[20] = 1'b1;
    src[6] = 1'b1;
    ticks(4);
    chk(pend_id == 5'd6, "R9 lowest wins", 32'(pend_id), 6);
    chk(pend_none == 1'b0, "R9 none low", 32'(pend_none), 0);
    wr(3'd1, ~bit_of(6));
    rd(3'd2, bit_of(6), 0, "R8 disabled masked");
    rd(3'd2, bit_of(20), bit_of(20), "R8 enabled masked");
    tick();
    chk(pend_id == 5'd20, "R9 next source", 32'(pend_id), 20);

    // R10: routing
    wr(3'd5, bit_of(20));
    tick();
    chk(irq_crit == 1'b1 && irq_ncrit == 1'b0, "R10 to critical",
        {irq_crit, irq_ncrit}, 2);
    wr(3'd5, '0);
    tick();
    chk(irq_crit == 1'b0 && irq_ncrit == 1'b1, "R10 to non-critical",
        {irq_crit, irq_ncrit}, 1);

    // R12: read-back and read-only masked register
    wr(3'd2, '0);
    rd(3'd2, bit_of(20), bit_of(20), "R12 masked write ignored");
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, '1, 32'h1234_5678, "R12 sense readback");
    rd(3'd1, '1, ~bit_of(6), "R12 enable readback");

    // Pseudo-random run checked against the model each clock.
    for (int c = 0; c < 4000; c++) begin
      lfsr = nxt(lfsr);
      if (lfsr[5]) src[lfsr[4:0]] = ~src[lfsr[4:0]];
      if (lfsr[8:6] == 3'd0) begin
        reg_addr = lfsr[11:9];
        reg_wdata = nxt(lfsr);
        reg_wr = 1'b1;
      end else begin
        reg_wr = 1'b0;
        reg_addr = lfsr[14:12];
      end
      tick();
    end
    reg_wr = 1'b0;
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule